// File: doc/BRIEF.md
# Nonvolatile byte store controller with ready interrupt

The block is a memory-mapped controller for a small on-chip nonvolatile byte store. Software reaches it through four byte registers, picked by a 2-bit select: control (0), data (1), address low (2) and address high (3). A byte is written in two steps. Software first sets the arming bit, which opens a short window. Within that window it sets the write-enable bit. The write-enable bit then stays high as a busy indicator for the whole programmed write latency. At the end of that time the data byte is committed to the store.

A read command copies the addressed byte into the data register at once. A level-sensitive ready interrupt request is high whenever the interrupt is enabled and no write is running. An accepted write start also raises a short stall request toward the CPU.

The store is modelled as an internal byte array with a parameterised write latency.

Top module: `nvs_ctrl`

## Requirements
- R1: After reset, the control register reads 0x00, irq_o and stall_o are 0, and every byte of the store holds 0xFF.
- R2: Control register layout: bit 0 is the read command, bit 1 is write-enable/busy, bit 2 is arming, bit 3 is interrupt-enable, and bits 5:4 are the mode. A control write updates only bits 5:1. Bits 7:6 and bit 0 always read 0.
- R3: Writing the arming bit as 1 sets it for ARM_CYC (4) cycles, after which hardware clears it. A write start is accepted only if arming was set when the start is written. An accepted start clears arming.
- R4: After an accepted start, bit 1 reads 1 for exactly WR_LAT cycles and then 0. In the cycle it clears, the data byte held at start is stored at the address held at start. Writing bit 1 as 0 does not end a running write.
- R5: A start written without a live arming window leaves bit 1 at 0 and the store unchanged.
- R6: irq_o equals interrupt-enable AND NOT busy AND NOT read-muted. Setting interrupt-enable while idle raises irq_o in the next cycle.
- R7: A control write with bit 3 = 0 drops irq_o. An accepted read command mutes irq_o until interrupt-enable goes from 0 to 1, until it is written 0, or until a write starts.
- R8: An accepted write start drives stall_o high for exactly 2 cycles, starting in the cycle after the start.
- R9: A read command copies the addressed byte into the data register on the same clock edge. Bit 0 does not stay set.
- R10: While a write is running, write-start and read commands are ignored, and the data register keeps its value.
- R11: The store index is the 16-bit value {address high, address low} taken modulo DEPTH (1024).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 control, 1 data, 2 address low, 3 address high |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Read value of the selected register |
| irq_o | output | 1 | Level ready-interrupt request |
| stall_o | output | 1 | CPU stall request |

## Verification
The write path is tried in four ways:
- a start inside the arming window, which shows that the busy time lasts exactly WR_LAT and that the byte is committed;
- a start with no arming, which shows that nothing happens;
- a start after the window has expired, which shows that the window really ends;
- a start whose address registers point above the array and are changed while busy, which separates the captured address from the live one and checks the wrap.

Read and write commands issued mid-write show that busy blocks them. A sequence of interrupt-enable writes, read commands and writes separates the idle-level behaviour from the read mute and from busy. Every cycle, the outputs are compared against a behavioural model.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_ALO  = 2'd2,
    SEL_AHI  = 2'd3
  } reg_sel_e;

  localparam int unsigned B_RD  = 0;
  localparam int unsigned B_WE  = 1;
  localparam int unsigned B_ARM = 2;
  localparam int unsigned B_IE  = 3;
  localparam int unsigned B_M0  = 4;
  localparam int unsigned B_M1  = 5;
endpackage

// File: rtl/nvs_countdown.sv
module nvs_countdown #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (load_i)            cnt_o <= load_val_i;
    else if (clr_i)             cnt_o <= '0;
    else if (cnt_o != '0)       cnt_o <= cnt_o - W'(1);
  end
endmodule

// File: rtl/nvs_array.sv
module nvs_array #(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/nvs_ctrl.sv
module nvs_ctrl
  import nvs_pkg::*;
#(
  parameter int unsigned DEPTH     = 1024,
  parameter int unsigned WR_LAT    = 16,
  parameter int unsigned ARM_CYC   = 4,
  parameter int unsigned STALL_CYC = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [1:0] reg_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o,
  output logic       stall_o
);
  localparam int unsigned AW      = $clog2(DEPTH);
  localparam int unsigned LAT_W   = $clog2(WR_LAT + 1);
  localparam int unsigned ARM_W   = $clog2(ARM_CYC + 1);
  localparam int unsigned STALL_W = $clog2(STALL_CYC + 1);

  logic [7:0]         data_q, alo_q, ahi_q, cap_data_q;
  logic [AW-1:0]      cap_addr_q;
  logic [1:0]         mode_q;
  logic               ie_q, mute_q;
  logic [LAT_W-1:0]   lat_cnt;
  logic [ARM_W-1:0]   arm_cnt;
  logic [STALL_W-1:0] stall_cnt;
  logic [15:0]        addr_full;
  logic [AW-1:0]      addr_idx;
  logic [7:0]         mem_rdata;
  logic               ctrl_wr, busy, armed, start, rd_ok, done, arm_load, arm_clr;

  assign ctrl_wr   = wr_en_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
  assign busy      = (lat_cnt != '0);
  assign armed     = (arm_cnt != '0);
  assign start     = ctrl_wr && wr_data_i[B_WE] && !busy && armed;
  assign rd_ok     = ctrl_wr && wr_data_i[B_RD] && !busy;
  assign done      = (lat_cnt == LAT_W'(1));
  assign arm_load  = ctrl_wr && wr_data_i[B_ARM] && !start;
  assign arm_clr   = ctrl_wr && !arm_load;
  assign addr_full = {ahi_q, alo_q};
  assign addr_idx  = AW'(addr_full % 16'(DEPTH));

  nvs_countdown #(.W(LAT_W)) u_lat (
    .clk_i, .rst_ni, .load_i(start), .load_val_i(LAT_W'(WR_LAT)),
    .clr_i(1'b0), .cnt_o(lat_cnt)
  );

  nvs_countdown #(.W(ARM_W)) u_arm (
    .clk_i, .rst_ni, .load_i(arm_load), .load_val_i(ARM_W'(ARM_CYC)),
    .clr_i(arm_clr), .cnt_o(arm_cnt)
  );

  nvs_countdown #(.W(STALL_W)) u_stall (
    .clk_i, .rst_ni, .load_i(start), .load_val_i(STALL_W'(STALL_CYC)),
    .clr_i(1'b0), .cnt_o(stall_cnt)
  );

  nvs_array #(.DEPTH(DEPTH)) u_array (
    .clk_i, .rst_ni, .we_i(done), .waddr_i(cap_addr_q), .wdata_i(cap_data_q),
    .raddr_i(addr_idx), .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q     <= '0;
      alo_q      <= '0;
      ahi_q      <= '0;
      ie_q       <= 1'b0;
      mode_q     <= '0;
      mute_q     <= 1'b0;
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (reg_sel_e'(reg_sel_i))
          SEL_DATA: data_q <= wr_data_i;
          SEL_ALO:  alo_q  <= wr_data_i;
          SEL_AHI:  ahi_q  <= wr_data_i;
          default: begin
            ie_q   <= wr_data_i[B_IE];
            mode_q <= wr_data_i[B_M1:B_M0];
          end
        endcase
      end
      if (rd_ok) data_q <= mem_rdata;
      // mute: set by read, lifted by start, ie write 0, or ie rising
      if (rd_ok)
        mute_q <= 1'b1;
      else if (start || (ctrl_wr && (!wr_data_i[B_IE] || !ie_q)))
        mute_q <= 1'b0;
      if (start) begin
        cap_addr_q <= addr_idx;
        cap_data_q <= data_q;
      end
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel_i))
      SEL_DATA: rd_data_o = data_q;
      SEL_ALO:  rd_data_o = alo_q;
      SEL_AHI:  rd_data_o = ahi_q;
      default:  rd_data_o = {2'b00, mode_q, ie_q, armed, busy, 1'b0};
    endcase
  end

  assign irq_o   = ie_q && !busy && !mute_q;
  assign stall_o = (stall_cnt != '0);
endmodule

// File: rtl/nvs_ctrl_chk.sv
module nvs_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ctrl_wr,
  input logic [7:0] wdat,
  input logic       busy,
  input logic       armed,
  input logic       irq_o,
  input logic       stall_o,
  input logic [7:0] data_q
);
  // R4 / R5: busy only rises after a write-start request that found arming live
  a_r4_start_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(armed && ctrl_wr && wdat[1]));

  // R3: an accepted start consumes the arming window
  a_r3_arm_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> !armed);

  // R8: stall begins with the start
  a_r8_stall_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> stall_o);

  // R8: stall never exceeds two cycles
  a_r8_stall_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && $past(stall_o) |=> !stall_o);

  // R6: no ready request while busy
  a_r6_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !busy);

  // R7: writing interrupt-enable low drops the request
  a_r7_ie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wdat[3] |=> !irq_o);

  // R10: control commands during a write leave the data register alone
  a_r10_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && ctrl_wr |=> $stable(data_q));
endmodule

bind nvs_ctrl nvs_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr(ctrl_wr), .wdat(wr_data_i),
  .busy(busy), .armed(armed), .irq_o(irq_o), .stall_o(stall_o), .data_q(data_q)
);

// File: tb/nvs_ctrl_tb.sv
`timescale 1ns/1ps
module nvs_ctrl_tb;
  localparam int DEPTH  = 1024;
  localparam int WR_LAT = 12;
  localparam int ARM    = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [7:0] wd = 8'h00;
  logic [7:0] rd;
  logic       irq, stall;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  nvs_ctrl #(.DEPTH(DEPTH), .WR_LAT(WR_LAT), .ARM_CYC(ARM), .STALL_CYC(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .reg_sel_i(sel), .wr_data_i(wd),
    .rd_data_o(rd), .irq_o(irq), .stall_o(stall)
  );

  // behavioural reference
  int m_mem [DEPTH];
  int m_data, m_alo, m_ahi, m_ie, m_mode, m_arm, m_lat, m_stall, m_mute, m_wa, m_wd;

  function automatic int m_addr();
    return ((m_ahi * 256) + m_alo) % DEPTH;
  endfunction

  function automatic int m_rd(input int s);
    case (s)
      1: return m_data;
      2: return m_alo;
      3: return m_ahi;
      default: return m_mode * 16 + m_ie * 8 + (m_arm > 0) * 4 + (m_lat > 0) * 2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_mem[i]) m_mem[i] = 255;
      m_data = 0; m_alo = 0; m_ahi = 0; m_ie = 0; m_mode = 0;
      m_arm = 0; m_lat = 0; m_stall = 0; m_mute = 0; m_wa = 0; m_wd = 0;
    end else begin
      int busy0, arm0, ie0, v, st, rdok;
      busy0 = (m_lat > 0);
      arm0 = m_arm;
      ie0 = m_ie;
      v = wd;
      if (m_lat > 0) begin
        m_lat--;
        if (m_lat == 0) m_mem[m_wa] = m_wd;
      end
      if (m_stall > 0) m_stall--;
      if (m_arm > 0) m_arm--;
      if (we) begin
        case (sel)
          2'd1: m_data = v;
          2'd2: m_alo = v;
          2'd3: m_ahi = v;
          default: begin
            st = v[1] && !busy0 && (arm0 > 0);
            rdok = v[0] && !busy0;
            m_ie = v[3];
            m_mode = (v >> 4) & 3;
            m_arm = (v[2] && !st) ? ARM : 0;
            if (rdok) m_mute = 1;
            else if (st || !v[3] || !ie0) m_mute = 0;
            if (st) begin
              m_wa = m_addr();
              m_wd = m_data;
              m_lat = WR_LAT;
              m_stall = 2;
            end
            if (rdok) m_data = m_mem[m_addr()];
          end
        endcase
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // per-cycle compare against the model
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk("R6 irq model", int'(irq), int'(m_ie && m_lat == 0 && !m_mute));
      chk("R8 stall model", int'(stall), int'(m_stall > 0));
      chk("R2 readback model", int'(rd), m_rd(int'(sel)));
    end
  end

  task automatic wr(input int s, input int v);
    @(negedge clk); #1;
    we = 1'b1; sel = 2'(s); wd = 8'(v);
    @(negedge clk); #1;
    we = 1'b0; sel = 2'd0; wd = 8'h00;
  endtask

  task automatic peek(input int s, output int v);
    #0.5 sel = 2'(s);
    #0.5 v = int'(rd);
    sel = 2'd0;
  endtask

  task automatic rd_byte(input int a, output int v);
    wr(3, a / 256);
    wr(2, a % 256);
    wr(0, 8'h01);
    peek(1, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    int v, n;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    #1;
    peek(0, v); chk("R1 ctrl reset", v, 0);
    chk("R1 irq reset", int'(irq), 0);
    chk("R1 stall reset", int'(stall), 0);
    rd_byte(5, v); chk("R1/R9 erased byte", v, 8'hFF);
    peek(0, v); chk("R9 read bit self-clears", v, 0);

    wr(0, 8'hF0); peek(0, v); chk("R2 write mask", v, 8'h30);
    wr(0, 8'h00);

    // unarmed start
    wr(1, 8'h5A); wr(3, 0); wr(2, 15);
    wr(0, 8'h02); peek(0, v); chk("R5 unarmed start", v, 0);
    idle(WR_LAT + 2);
    rd_byte(15, v); chk("R5 store unchanged", v, 8'hFF);

    // armed write
    wr(1, 8'h5A); wr(2, 15);
    wr(0, 8'h04); peek(0, v); chk("R3 arming set", v, 8'h04);
    wr(0, 8'h02);
    chk("R8 stall first", int'(stall), 1);
    peek(0, v); chk("R3/R4 busy, arm cleared", v, 8'h02);
    n = 0;
    while ((int'(rd) & 2) != 0 && n < 1000) begin
      @(negedge clk); #1; n++;
      if (n == 1) chk("R8 stall second", int'(stall), 1);
      if (n == 2) chk("R8 stall ends", int'(stall), 0);
    end
    chk("R4 busy length", n, WR_LAT);
    rd_byte(15, v); chk("R4 byte committed", v, 8'h5A);

    // write above array, addr/data changed while busy
    wr(1, 8'hA7); wr(3, 4); wr(2, 3);
    wr(0, 8'h04); wr(0, 8'h02);
    wr(2, 20); wr(3, 0); wr(1, 8'h11);
    wr(0, 8'h01); peek(1, v); chk("R10 read ignored while busy", v, 8'h11);
    wr(0, 8'h00); peek(0, v); chk("R4 busy survives bit1=0", v & 2, 2);
    wr(0, 8'h06);
    idle(WR_LAT + 2);
    peek(0, v); chk("R10 start ignored while busy", v & 2, 0);
    rd_byte(3, v); chk("R11 address wraps", v, 8'hA7);
    rd_byte(20, v); chk("R4 captured address", v, 8'hFF);

    // expired window
    wr(1, 8'h33); wr(2, 40);
    wr(0, 8'h04); idle(ARM + 2);
    peek(0, v); chk("R3 arm expired", v, 0);
    wr(0, 8'h02); peek(0, v); chk("R3 late start rejected", v, 0);
    idle(WR_LAT + 2);
    rd_byte(40, v); chk("R3 no late commit", v, 8'hFF);

    // interrupt behaviour
    wr(0, 8'h08); chk("R6 irq on enable while idle", int'(irq), 1);
    wr(0, 8'h00); chk("R7 irq off on disable", int'(irq), 0);
    wr(0, 8'h08); chk("R6 irq again", int'(irq), 1);
    wr(0, 8'h09); chk("R7 read mutes irq", int'(irq), 0);
    wr(0, 8'h08); chk("R7 mute holds with ie kept", int'(irq), 0);
    wr(0, 8'h00); wr(0, 8'h08); chk("R7 re-enable lifts mute", int'(irq), 1);
    wr(1, 8'hC3); wr(2, 50);
    wr(0, 8'h0C); wr(0, 8'h0A);
    chk("R6 irq low while busy", int'(irq), 0);
    idle(WR_LAT + 1);
    chk("R6 irq back when idle", int'(irq), 1);
    rd_byte(50, v); chk("R4 write with ie", v, 8'hC3);

    idle(2);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule